// File: doc/BRIEF.md
# Transmit Descriptor Ring Engine

This block walks a ring of 16-byte transmit descriptors held in system memory, gathers the buffer fragments they point to into frames and streams the frame bytes out, one byte per cycle, with a marker on the final byte. Software fills descriptors, hands them over by setting the ownership bit and then writes a poll-demand strobe. The engine first skips forward from its current pointer to a plausible starting descriptor. It then processes owned descriptors one after another, hands each back by clearing ownership in word 0, and follows the ring, wrapping to the base after a descriptor marked end-of-ring.

Each descriptor is four 32-bit words. Word 0 carries the fragment length and the control flags. Word 1 carries two interrupt requests. Word 3 holds the word-aligned buffer address. Buffer words are read from memory one per beat, and their bytes are sent out starting with the least significant. Frames are limited to a standard or a jumbo byte cap. Three single-cycle pulses report a completed frame, a fetched buffer, and a stop on a descriptor the engine does not own.

Top module: `txring_engine`

## Requirements
- R1: After reset the engine is idle, with no memory request, no output byte and no interrupt pulse.
- R2: A poll strobe starts a walk only when dma_en is high and the engine is idle. A strobe while dma_en is low leaves the engine idle and issues no memory request.
- R3: A walk begins at the current pointer and skips ahead 16 bytes at a time until it reaches a descriptor whose word 0 has bit 29 (first segment) or bit 15 (end of ring) set. That descriptor is the first one processed.
- R4: When word 0 of the descriptor being processed has bit 31 (ownership) clear, the engine pulses irq_no_desc, goes idle and keeps that descriptor's address as its pointer. The next walk starts its search there.
- R5: For an owned descriptor, word 0 bits 13:0 give the fragment length and word 3 gives the buffer address. The bytes are streamed in little-endian order within each memory word, fragments are concatenated, and out_last marks the final byte of a descriptor whose word 0 bit 28 (last segment) is set.
- R6: The bytes of one frame are limited to 1522, or to 9220 when jumbo is high. A fragment that would exceed the limit is truncated to the remaining room.
- R7: After each owned descriptor, the engine writes word 0 back to the descriptor address with bit 31 cleared and every other bit unchanged. It writes no other word.
- R8: After a descriptor with word 0 bit 15 set, the next descriptor is at the ring base. Otherwise it is at the current address plus 16.
- R9: irq_frame_done pulses once for each descriptor that has the last-segment bit set and word 1 bit 31 set.
- R10: irq_buf_fetched pulses once for each processed descriptor that has word 1 bit 30 set.
- R11: A base_wr strobe while idle sets both the ring base and the current pointer to base_in.
- R12: A poll strobe that arrives while a walk is in progress has no effect. The engine stays idle once that walk ends.
- R13: When an ownership stop happens in the middle of a frame, the final byte already fetched carries out_last, and the next walk starts a new frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dma_en | input | 1 | Transmit DMA enable; gates poll strobes |
| poll | input | 1 | Poll-demand strobe |
| base_wr | input | 1 | Ring-base write strobe, honoured while idle |
| base_in | input | AW | New ring base address |
| jumbo | input | 1 | Selects the jumbo frame-length cap |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | AW | Word-aligned request address |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Completes the current request; read data valid |
| mem_rdata | input | 32 | Read data |
| out_valid | output | 1 | Output byte valid |
| out_data | output | 8 | Output byte |
| out_last | output | 1 | Final byte of a frame |
| irq_frame_done | output | 1 | Frame-completion interrupt pulse |
| irq_buf_fetched | output | 1 | Buffer-fetched interrupt pulse |
| irq_no_desc | output | 1 | No owned descriptor interrupt pulse |
| busy | output | 1 | A walk is in progress |

## Verification
The assertions assume a memory slave that acknowledges each request exactly once, in a cycle where the request is high, and that returns read data in that same cycle. The bench responder meets this: it raises mem_ack for a single cycle, after a delay that varies from zero to two cycles, and drops it before looking at the next request. The assertions and the stimulus also assume that software keeps every ring terminated. Every ring the bench builds has a descriptor with the first-segment or end-of-ring bit ahead of the pointer, and a descriptor the engine does not own somewhere along the path. Ring-base writes are issued only while busy is low. The bench leaves descriptor memory untouched while a walk is running.

// File: rtl/txring_pkg.sv
package txring_pkg;

    localparam int WORD_W     = 32;
    localparam int DESC_BYTES = 16;
    localparam int LEN_W      = 14;

    // word 0 flag positions (software visible)
    localparam int B_OWN   = 31;
    localparam int B_FIRST = 29;
    localparam int B_LAST  = 28;
    localparam int B_EOR   = 15;
    // word 1 request positions
    localparam int B_FRM_IRQ = 31;
    localparam int B_BUF_IRQ = 30;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DESC,
        ST_CTRL,
        ST_BPTR,
        ST_FETCH,
        ST_EMIT,
        ST_CLOSE,
        ST_WBACK
    } walk_st_t;

    typedef struct packed {
        logic             own;
        logic             first;
        logic             last;
        logic             eor;
        logic [LEN_W-1:0] len;
    } ctl_word_t;

    function automatic ctl_word_t split_ctl(input logic [WORD_W-1:0] w);
        ctl_word_t c;
        c.own   = w[B_OWN];
        c.first = w[B_FIRST];
        c.last  = w[B_LAST];
        c.eor   = w[B_EOR];
        c.len   = w[LEN_W-1:0];
        return c;
    endfunction

    // bytes of a fragment that still fit under the frame cap
    function automatic logic [LEN_W-1:0] fit_len(input logic [LEN_W-1:0] len,
                                                 input logic [LEN_W-1:0] used,
                                                 input logic [LEN_W-1:0] cap);
        logic [LEN_W-1:0] room;
        room = (used >= cap) ? '0 : cap - used;
        return (len > room) ? room : len;
    endfunction

endpackage

// File: rtl/txring_outbuf.sv
module txring_outbuf (
    input  logic       clk,
    input  logic       rst,
    input  logic       push_v,
    input  logic [7:0] push_d,
    input  logic       flush,
    output logic       out_valid,
    output logic [7:0] out_data,
    output logic       out_last
);
    // one byte is held back so the end-of-frame marker can be attached
    // even when the closing fragment contributes no bytes
    logic       hold_v;
    logic [7:0] hold_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_v    <= 1'b0;
            hold_d    <= '0;
            out_valid <= 1'b0;
            out_data  <= '0;
            out_last  <= 1'b0;
        end else begin
            out_valid <= 1'b0;
            out_last  <= 1'b0;
            if (push_v) begin
                if (hold_v) begin
                    out_valid <= 1'b1;
                    out_data  <= hold_d;
                end
                hold_d <= push_d;
                hold_v <= 1'b1;
            end else if (flush && hold_v) begin
                out_valid <= 1'b1;
                out_last  <= 1'b1;
                out_data  <= hold_d;
                hold_v    <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/txring_walker.sv
module txring_walker
    import txring_pkg::*;
#(
    parameter int AW        = 32,
    parameter int STD_MAX   = 1522,
    parameter int JUMBO_MAX = 9220
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              dma_en,
    input  logic              poll,
    input  logic              base_wr,
    input  logic [AW-1:0]     base_in,
    input  logic              jumbo,
    output logic              mem_req,
    output logic              mem_we,
    output logic [AW-1:0]     mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              push_v,
    output logic [7:0]        push_d,
    output logic              flush,
    output logic              irq_frame_done,
    output logic              irq_buf_fetched,
    output logic              irq_no_desc,
    output logic              busy
);
    localparam logic [AW-1:0]    STEP      = AW'(DESC_BYTES);
    localparam logic [AW-1:0]    OFS_CTRL  = AW'(4);
    localparam logic [AW-1:0]    OFS_BPTR  = AW'(12);
    localparam logic [AW-1:0]    OFS_WORD  = AW'(WORD_W / 8);
    localparam logic [AW-1:0]    ALIGN_MSK = ~AW'(WORD_W / 8 - 1);
    localparam logic [LEN_W-1:0] CAP_STD   = LEN_W'(STD_MAX);
    localparam logic [LEN_W-1:0] CAP_JUMBO = LEN_W'(JUMBO_MAX);

    walk_st_t          st;
    logic [AW-1:0]     cur, base, bptr;
    logic [WORD_W-1:0] w0, word;
    logic              frm_req, buf_req, seeking;
    logic [LEN_W-1:0]  left, used;
    logic [1:0]        lane;

    ctl_word_t         cw, rw;
    logic [LEN_W-1:0]  cap, take;
    logic              skip, stop;

    assign cw   = split_ctl(w0);
    assign rw   = split_ctl(mem_rdata);
    assign cap  = jumbo ? CAP_JUMBO : CAP_STD;
    assign take = fit_len(cw.len, used, cap);
    assign skip = seeking && !(rw.first || rw.eor);
    assign stop = (st == ST_DESC) && mem_ack && !skip && !rw.own;

    assign busy   = (st != ST_IDLE);
    assign push_v = (st == ST_EMIT);
    assign push_d = 8'(word >> (8 * lane));
    assign flush  = ((st == ST_CLOSE) && cw.last) || stop;

    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = cur;
        mem_wdata = w0 & ~(WORD_W'(1) << B_OWN);
        unique case (st)
            ST_DESC:  mem_req = 1'b1;
            ST_CTRL: begin
                mem_req  = 1'b1;
                mem_addr = cur + OFS_CTRL;
            end
            ST_BPTR: begin
                mem_req  = 1'b1;
                mem_addr = cur + OFS_BPTR;
            end
            ST_FETCH: begin
                mem_req  = 1'b1;
                mem_addr = bptr;
            end
            ST_WBACK: begin
                mem_req = 1'b1;
                mem_we  = 1'b1;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st              <= ST_IDLE;
            cur             <= '0;
            base            <= '0;
            bptr            <= '0;
            w0              <= '0;
            word            <= '0;
            frm_req         <= 1'b0;
            buf_req         <= 1'b0;
            seeking         <= 1'b0;
            left            <= '0;
            used            <= '0;
            lane            <= '0;
            irq_frame_done  <= 1'b0;
            irq_buf_fetched <= 1'b0;
            irq_no_desc     <= 1'b0;
        end else begin
            irq_frame_done  <= 1'b0;
            irq_buf_fetched <= 1'b0;
            irq_no_desc     <= 1'b0;
            unique case (st)
                ST_IDLE: begin
                    if (base_wr) begin
                        base <= base_in;
                        cur  <= base_in;
                    end
                    if (poll && dma_en) begin
                        seeking <= 1'b1;
                        used    <= '0;
                        st      <= ST_DESC;
                    end
                end
                ST_DESC: if (mem_ack) begin
                    w0 <= mem_rdata;
                    if (skip) begin
                        cur <= cur + STEP;
                    end else if (!rw.own) begin
                        irq_no_desc <= 1'b1;
                        seeking     <= 1'b0;
                        used        <= '0;
                        st          <= ST_IDLE;
                    end else begin
                        seeking <= 1'b0;
                        st      <= ST_CTRL;
                    end
                end
                ST_CTRL: if (mem_ack) begin
                    frm_req <= mem_rdata[B_FRM_IRQ];
                    buf_req <= mem_rdata[B_BUF_IRQ];
                    st      <= ST_BPTR;
                end
                ST_BPTR: if (mem_ack) begin
                    bptr <= AW'(mem_rdata) & ALIGN_MSK;
                    left <= take;
                    used <= used + take;
                    lane <= '0;
                    st   <= (take == '0) ? ST_CLOSE : ST_FETCH;
                end
                ST_FETCH: if (mem_ack) begin
                    word <= mem_rdata;
                    bptr <= bptr + OFS_WORD;
                    st   <= ST_EMIT;
                end
                ST_EMIT: begin
                    left <= left - 1'b1;
                    lane <= lane + 1'b1;
                    if (left == LEN_W'(1))
                        st <= ST_CLOSE;
                    else if (lane == 2'd3)
                        st <= ST_FETCH;
                end
                ST_CLOSE: begin
                    if (cw.last)
                        used <= '0;
                    st <= ST_WBACK;
                end
                ST_WBACK: if (mem_ack) begin
                    irq_frame_done  <= cw.last && frm_req;
                    irq_buf_fetched <= buf_req;
                    cur             <= cw.eor ? base : cur + STEP;
                    st              <= ST_DESC;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/txring_engine.sv
module txring_engine
    import txring_pkg::*;
#(
    parameter int AW        = 32,
    parameter int STD_MAX   = 1522,
    parameter int JUMBO_MAX = 9220
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              dma_en,
    input  logic              poll,
    input  logic              base_wr,
    input  logic [AW-1:0]     base_in,
    input  logic              jumbo,
    output logic              mem_req,
    output logic              mem_we,
    output logic [AW-1:0]     mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              out_valid,
    output logic [7:0]        out_data,
    output logic              out_last,
    output logic              irq_frame_done,
    output logic              irq_buf_fetched,
    output logic              irq_no_desc,
    output logic              busy
);
    logic       push_v;
    logic [7:0] push_d;
    logic       flush;

    txring_walker #(
        .AW(AW), .STD_MAX(STD_MAX), .JUMBO_MAX(JUMBO_MAX)
    ) u_walk (
        .clk(clk), .rst(rst), .dma_en(dma_en), .poll(poll),
        .base_wr(base_wr), .base_in(base_in), .jumbo(jumbo),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .push_v(push_v), .push_d(push_d), .flush(flush),
        .irq_frame_done(irq_frame_done), .irq_buf_fetched(irq_buf_fetched),
        .irq_no_desc(irq_no_desc), .busy(busy)
    );

    txring_outbuf u_out (
        .clk(clk), .rst(rst), .push_v(push_v), .push_d(push_d),
        .flush(flush), .out_valid(out_valid), .out_data(out_data),
        .out_last(out_last)
    );
endmodule

// File: rtl/txring_checker.sv
module txring_checker #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst,
    input logic          dma_en,
    input logic          poll,
    input logic          base_wr,
    input logic          mem_req,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr,
    input logic [31:0]   mem_wdata,
    input logic          mem_ack,
    input logic          out_valid,
    input logic          out_last,
    input logic          irq_frame_done,
    input logic          irq_buf_fetched,
    input logic          irq_no_desc,
    input logic          busy
);
    logic armed = 1'b0;
    always_ff @(posedge clk) if (rst) armed <= 1'b1;

    p_reset_idle_r1: assert property (@(posedge clk)
        (armed && $past(rst)) |-> (!busy && !mem_req && !out_valid && !irq_no_desc));

    p_poll_gated_r2: assert property (@(posedge clk) disable iff (rst)
        (!busy && poll && !dma_en) |=> !busy);

    p_poll_start_r2: assert property (@(posedge clk) disable iff (rst)
        (!busy && poll && dma_en) |=> busy);

    p_wb_word0_r7: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we) |-> (mem_addr[3:0] == 4'h0 && !mem_wdata[31]));

    p_req_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    p_nodesc_stops_r4: assert property (@(posedge clk) disable iff (rst)
        irq_no_desc |-> (!busy && !irq_frame_done && !irq_buf_fetched));

    p_last_valid_r5: assert property (@(posedge clk) disable iff (rst)
        out_last |-> out_valid);

    p_base_idle_r11: assert property (@(posedge clk) disable iff (rst)
        (!busy && base_wr && !poll) |=> !busy);
endmodule

bind txring_engine txring_checker #(.AW(AW)) u_chk (.*);

// File: tb/sim_txring_engine.sv
module sim_txring_engine;
    localparam int AW   = 32;
    localparam int MEMW = 4096;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic          dma_en = 1'b0, poll = 1'b0, base_wr = 1'b0, jumbo = 1'b0;
    logic [AW-1:0] base_in = '0;
    logic          mem_req, mem_we;
    logic [AW-1:0] mem_addr;
    logic [31:0]   mem_wdata;
    logic          mem_ack = 1'b0;
    logic [31:0]   mem_rdata = '0;
    logic          out_valid, out_last;
    logic [7:0]    out_data;
    logic          irq_frame_done, irq_buf_fetched, irq_no_desc, busy;

    txring_engine u0 (
        .clk(clk), .rst(rst), .dma_en(dma_en), .poll(poll), .base_wr(base_wr),
        .base_in(base_in), .jumbo(jumbo), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
        .mem_rdata(mem_rdata), .out_valid(out_valid), .out_data(out_data),
        .out_last(out_last), .irq_frame_done(irq_frame_done),
        .irq_buf_fetched(irq_buf_fetched), .irq_no_desc(irq_no_desc), .busy(busy)
    );

    logic [31:0] mem    [MEMW];
    logic [31:0] shadow [MEMW];

    typedef struct { logic [7:0] d; logic last; } xb_t;
    typedef struct { logic [AW-1:0] a; logic [31:0] d; } xw_t;
    typedef struct { logic [2:0] k; logic [AW-1:0] a; } xe_t;
    xb_t q_b[$];
    xw_t q_w[$];
    xe_t q_e[$];

    int n_chk = 0, n_fail = 0;
    int unsigned cyc = 0;
    string tag_b = "R5", tag_e = "R9";
    logic [AW-1:0] m_cur = '0, m_base = '0;
    logic [AW-1:0] last_rd = '0, first_wr = '0;
    bit wr_seen = 0, saw_req = 0;
    int dly = 0, seed = 0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [7:0] sbyte(input logic [AW-1:0] a);
        logic [31:0] w;
        w = shadow[a[13:2]];
        return w[8*a[1:0] +: 8];
    endfunction

    // behavioural model of one walk, run when a poll is accepted
    task automatic model_poll();
        logic [AW-1:0] a, ba;
        logic [31:0]   w0, w1;
        int fsz, nb, cap, len, take, guard;
        a = m_cur; fsz = 0; nb = 0; guard = 0;
        while (!(shadow[a[13:2]][29] || shadow[a[13:2]][15]) && guard < 256) begin
            a = a + 16; guard++;
        end
        forever begin
            w0 = shadow[a[13:2]];
            if (!w0[31]) begin
                if (nb > 0) q_b[q_b.size()-1].last = 1'b1;
                q_e.push_back('{3'b100, a});
                m_cur = a;
                break;
            end
            w1  = shadow[(a + 4) >> 2];
            ba  = shadow[(a + 12) >> 2];
            len = int'(w0[13:0]);
            cap = jumbo ? 9220 : 1522;
            take = (fsz + len > cap) ? cap - fsz : len;
            for (int i = 0; i < take; i++)
                q_b.push_back('{sbyte(ba + AW'(i)), 1'b0});
            nb  += take;
            fsz += take;
            if (w0[28]) begin
                if (nb > 0) q_b[q_b.size()-1].last = 1'b1;
                nb = 0; fsz = 0;
            end
            q_w.push_back('{a, w0 & 32'h7FFF_FFFF});
            shadow[a[13:2]] = w0 & 32'h7FFF_FFFF;
            if ((w0[28] && w1[31]) || w1[30])
                q_e.push_back('{{1'b0, w0[28] && w1[31], w1[30]}, a});
            a = w0[15] ? m_base : a + 16;
        end
    endtask

    task automatic put(input logic [AW-1:0] a, input logic [31:0] d);
        mem[a[13:2]] = d; shadow[a[13:2]] = d;
    endtask

    task automatic desc(input logic [AW-1:0] a, input logic [31:0] w0,
                        input logic [31:0] w1, input logic [31:0] ba);
        put(a, w0); put(a + 4, w1); put(a + 8, 32'h0); put(a + 12, ba);
    endtask

    function automatic logic [31:0] ctl(input bit own, input bit first, input bit last,
                                        input bit eor, input int len);
        return {own, 1'b0, first, last, 12'h0, eor, 1'b0, 14'(len)};
    endfunction

    task automatic do_poll();
        @(negedge clk);
        poll = 1'b1;
        if (!busy && dma_en) model_poll();
        @(negedge clk);
        poll = 1'b0;
    endtask

    task automatic set_base(input logic [AW-1:0] a);
        @(negedge clk);
        base_wr = 1'b1; base_in = a; m_base = a; m_cur = a;
        @(negedge clk);
        base_wr = 1'b0;
    endtask

    task automatic wait_done(input string tag);
        do @(negedge clk); while (busy);
        repeat (4) @(negedge clk);
        chk(q_b.size() == 0, tag, "bytes left over", q_b.size(), 0);
        chk(q_w.size() == 0, "R7", "writebacks left over", q_w.size(), 0);
        chk(q_e.size() == 0, tag, "pulses left over", q_e.size(), 0);
    endtask

    // memory responder, stream/pulse monitor and watchdog
    always @(negedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            n_chk++; n_fail++;
            $display("FAIL R5 watchdog expired actual=%0d expected=0", cyc);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
        if (!rst) begin
            if (out_valid) begin
                if (q_b.size() == 0) chk(0, tag_b, "unexpected byte", out_data, 0);
                else begin
                    xb_t x;
                    x = q_b.pop_front();
                    chk(out_data == x.d && out_last == x.last, tag_b, "byte/last",
                        {out_last, out_data}, {x.last, x.d});
                end
            end
            if (irq_no_desc || irq_frame_done || irq_buf_fetched) begin
                logic [2:0] k;
                k = {irq_no_desc, irq_frame_done, irq_buf_fetched};
                if (q_e.size() == 0) chk(0, tag_e, "unexpected pulse", k, 0);
                else begin
                    xe_t e;
                    e = q_e.pop_front();
                    chk(k == e.k && (!e.k[2] || last_rd == e.a), tag_e, "pulse kind/addr",
                        {k, last_rd}, {e.k, e.a});
                end
            end
            if (mem_req) saw_req = 1;
            if (mem_ack) mem_ack = 1'b0;
            else if (mem_req) begin
                if (dly > 0) dly--;
                else begin
                    mem_ack = 1'b1;
                    if (mem_we) begin
                        if (!wr_seen) begin first_wr = mem_addr; wr_seen = 1; end
                        if (q_w.size() == 0) chk(0, "R7", "unexpected write", mem_addr, 0);
                        else begin
                            xw_t w;
                            w = q_w.pop_front();
                            chk(mem_addr == w.a && mem_wdata == w.d, "R7", "writeback addr/data",
                                {mem_addr, mem_wdata}, {w.a, w.d});
                        end
                        mem[mem_addr[13:2]] = mem_wdata;
                    end else begin
                        mem_rdata = mem[mem_addr[13:2]];
                        last_rd   = mem_addr;
                    end
                    seed++;
                    dly = seed % 3;
                end
            end
        end
    end

    initial begin
        for (int i = 0; i < MEMW; i++) begin
            mem[i]    = (i < 256) ? 32'h0 : (32'(i) * 32'h9E37_79B1) ^ 32'h5A5A_1234;
            shadow[i] = mem[i];
        end
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(!busy && !mem_req && !out_valid && !irq_no_desc && !irq_frame_done,
            "R1", "reset outputs", {busy, mem_req, out_valid}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy && !mem_req, "R1", "idle after reset", {busy, mem_req}, 0);

        // R2: poll while DMA disabled is ignored
        saw_req = 0;
        do_poll();
        repeat (10) @(negedge clk);
        chk(!busy && !saw_req, "R2", "poll with dma_en low", {busy, saw_req}, 0);
        dma_en = 1'b1;

        // R3 R8 R9 R10 R12: seek, multi-fragment frame, interrupts, wrap
        set_base(32'h0);
        desc(32'h00, 32'h0, 32'h0, 32'h1000);
        desc(32'h10, ctl(1, 1, 1, 0, 7), 32'hC000_0000, 32'h1000);
        desc(32'h20, ctl(1, 1, 0, 0, 5) | 32'h0008_0000, 32'h4000_0000, 32'h1100);
        desc(32'h30, ctl(1, 0, 1, 1, 6), 32'h8000_0000, 32'h1200);
        tag_b = "R5"; tag_e = "R9 R10 R8";
        wr_seen = 0;
        do_poll();
        repeat (3) @(negedge clk);
        do_poll();   // R12: ignored, engine busy
        wait_done("R5");
        chk(wr_seen && first_wr == 32'h10, "R3", "first processed descriptor", first_wr, 32'h10);
        saw_req = 0;
        repeat (20) @(negedge clk);
        chk(!busy && !saw_req, "R12", "no second walk", {busy, saw_req}, 0);

        // R4: pointer kept at the stop, next walk resumes there
        desc(32'h00, ctl(1, 1, 1, 0, 3), 32'h0, 32'h1300);
        tag_e = "R4";
        do_poll();
        wait_done("R4");

        // R11 R13: new base, ownership stop in the middle of a frame
        set_base(32'h40);
        desc(32'h40, ctl(1, 1, 0, 0, 9), 32'h0, 32'h1400);
        desc(32'h50, 32'h0, 32'h0, 32'h0);
        tag_b = "R13"; tag_e = "R11 R13";
        do_poll();
        wait_done("R13");

        // R6: standard cap truncates the second fragment
        set_base(32'h100);
        desc(32'h100, ctl(1, 1, 0, 0, 1000), 32'h0, 32'h1000);
        desc(32'h110, ctl(1, 0, 1, 1, 1000), 32'h8000_0000, 32'h1400);
        tag_b = "R6"; tag_e = "R6 R9";
        do_poll();
        wait_done("R6");

        // R6: jumbo cap on a single long fragment
        jumbo = 1'b1;
        set_base(32'h200);
        desc(32'h200, ctl(1, 1, 1, 1, 9300), 32'h8000_0000, 32'h1000);
        do_poll();
        wait_done("R6");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule